// File: doc/BRIEF.md
# Dirty scanline span coalescer

This block turns a stream of per-scanline dirty flags into a short list of update rectangles for a display pipeline. A frame begins with a start pulse that carries the frame height, the mode width and a full-update flag. Rows then arrive one per accepted beat, in order from row 0 to height minus 1. Each beat says whether that scanline changed. Consecutive dirty rows merge into one rectangle, given as a first row and a row count. Every rectangle covers the whole mode width, from column 0.

When the full-update flag is set, as after a mode change, the row stream is not consumed. A single rectangle that covers the whole frame is reported instead. Rectangles leave through a valid/ready handshake. The row intake stalls while a rectangle is waiting to be taken. A one-cycle done pulse marks the end of each frame's output.

Top module: `span_coalescer`

## Requirements
- R1: After reset, `rect_valid`, `frame_done` and `row_ready` are all low.
- R2: `frm_start` is taken only while the block is idle. It then latches `frm_height`, `frm_width` and `frm_full`. A start pulse or a change of those inputs during a frame has no effect on that frame's rectangles.
- R3: A span opens at the first dirty row seen while no span is open. Its rectangle reports that row index on `rect_y0`.
- R4: A clean row that arrives while a span is open closes the span. The rectangle count is the clean row's index minus the span's first row.
- R5: If a span is still open when the last row (index height minus 1) is dirty, the rectangle count runs to the frame height, so `rect_y0 + rect_rows` equals the height.
- R6: Every rectangle reports the width latched at frame start on `rect_width`, with column 0 as its left edge.
- R7: With `frm_full` set at start, exactly one rectangle (`rect_y0` = 0, `rect_rows` = height) is emitted, and `row_ready` stays low for the whole frame.
- R8: While `rect_valid` is high and `rect_ready` is low, the rectangle fields hold steady. `row_ready` is low whenever `rect_valid` is high.
- R9: Exactly one `frame_done` pulse follows each accepted start. It comes after the frame's last rectangle has been accepted, and it is never high together with `rect_valid`.
- R10: A frame with no dirty rows emits no rectangle and only the done pulse.
- R11: A height of 0 emits no rectangle, even with `frm_full` set, and still gives the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | Frame start pulse |
| frm_full | input | 1 | Report the whole frame and skip row scanning |
| frm_height | input | ROW_W | Number of scanlines in the frame |
| frm_width | input | COL_W | Mode width reported with each rectangle |
| row_valid | input | 1 | Row beat valid |
| row_dirty | input | 1 | Current scanline changed |
| row_ready | output | 1 | Row beat accepted when high with row_valid |
| rect_valid | output | 1 | Rectangle available |
| rect_ready | input | 1 | Downstream takes the rectangle |
| rect_y0 | output | ROW_W | First row of the rectangle |
| rect_rows | output | ROW_W | Row count of the rectangle |
| rect_width | output | COL_W | Column count, starting at column 0 |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is a span closing or flushing while the previous rectangle is still held back by a low `rect_ready`. In that case the intake stall must keep the next row from being lost or merged. The bench drops `rect_ready` at random on most cycles and inserts random gaps in `row_valid`. It also uses dense dirty patterns, such as alternating rows and single clean rows between long runs, so that rectangles back up against the row stream. Directed frames cover a span that opens on the last row, height 1, height 0, and a start pulse injected in the middle of a frame.

// File: rtl/span_coalescer_pkg.sv
// Shared types for the span coalescer.
package span_coalescer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } sc_state_e;
endpackage

// File: rtl/sc_span_track.sv
// Row counter and open-span tracker.
// Each accepted row steps the index. The module reports a closed span
// (first row and count) in the same cycle as the row that closes it.
// Assumes height >= 1 whenever a step occurs, and that clear precedes a frame.
module sc_span_track #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             dirty,
    input  logic [ROW_W-1:0] height,
    output logic             is_last,
    output logic             close_fire,
    output logic [ROW_W-1:0] close_y0,
    output logic [ROW_W-1:0] close_rows
);
    logic [ROW_W-1:0] row_idx_q;
    logic [ROW_W-1:0] start_q;
    logic             open_q;
    logic [ROW_W-1:0] base;

    // Last-row detect and span-close decode for the current beat.
    always_comb begin
        is_last    = (row_idx_q == height - ROW_W'(1));
        base       = open_q ? start_q : row_idx_q;
        close_fire = 1'b0;
        close_y0   = start_q;
        close_rows = '0;
        if (step) begin
            if (open_q && !dirty) begin
                close_fire = 1'b1;
                close_rows = row_idx_q - start_q;
            end else if (dirty && is_last) begin
                close_fire = 1'b1;
                close_y0   = base;
                close_rows = height - base;
            end
        end
    end

    // Row index, span-open flag and span start register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            row_idx_q <= '0;
            start_q   <= '0;
            open_q    <= 1'b0;
        end else if (step) begin
            row_idx_q <= row_idx_q + ROW_W'(1);
            if (close_fire) begin
                open_q <= 1'b0;
            end else if (dirty && !open_q) begin
                open_q  <= 1'b1;
                start_q <= row_idx_q;
            end
        end
    end

    // R4: a closed span never has zero rows
    p_rows_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        close_fire |-> (close_rows != '0));
endmodule

// File: rtl/sc_rect_slot.sv
// Single-entry holding register for one output rectangle, with valid/ready.
// Assumes load is asserted only while the slot is empty.
module sc_rect_slot #(
    parameter int ROW_W = 11,
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] in_y0,
    input  logic [ROW_W-1:0] in_rows,
    input  logic [COL_W-1:0] in_width,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_y0,
    output logic [ROW_W-1:0] out_rows,
    output logic [COL_W-1:0] out_width
);
    // Capture a rectangle on load; release it on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y0    <= '0;
            out_rows  <= '0;
            out_width <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_y0    <= in_y0;
            out_rows  <= in_rows;
            out_width <= in_width;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8: a stalled rectangle keeps its fields
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_y0)
                                       && $stable(out_rows) && $stable(out_width)));
    // R8: no load into an occupied slot
    p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);
endmodule

// File: rtl/span_coalescer.sv
// Dirty scanline span coalescer top.
// Frame FSM: idle -> scan rows (or emit a full-frame rectangle) -> drain -> done.
// Assumes rows arrive in order 0..height-1 after each accepted start.
module span_coalescer
    import span_coalescer_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_start,
    input  logic             frm_full,
    input  logic [ROW_W-1:0] frm_height,
    input  logic [COL_W-1:0] frm_width,
    input  logic             row_valid,
    input  logic             row_dirty,
    output logic             row_ready,
    output logic             rect_valid,
    input  logic             rect_ready,
    output logic [ROW_W-1:0] rect_y0,
    output logic [ROW_W-1:0] rect_rows,
    output logic [COL_W-1:0] rect_width,
    output logic             frame_done
);
    localparam int SUM_W = ROW_W + 1;

    sc_state_e        state_q;
    logic [ROW_W-1:0] height_q;
    logic [COL_W-1:0] width_q;
    logic             take_start;
    logic             full_go;
    logic             step;
    logic             is_last;
    logic             close_fire;
    logic [ROW_W-1:0] close_y0;
    logic [ROW_W-1:0] close_rows;
    logic             slot_load;
    logic [ROW_W-1:0] slot_y0;
    logic [ROW_W-1:0] slot_rows;
    logic [COL_W-1:0] slot_width;

    // Handshake and load-source selection.
    always_comb begin
        take_start = (state_q == ST_IDLE) && frm_start;
        full_go    = take_start && frm_full && (frm_height != '0);
        row_ready  = (state_q == ST_SCAN) && !rect_valid;
        step       = row_valid && row_ready;
        slot_load  = full_go || close_fire;
        slot_y0    = full_go ? '0 : close_y0;
        slot_rows  = full_go ? frm_height : close_rows;
        slot_width = full_go ? frm_width : width_q;
    end

    // Frame FSM, latched frame parameters and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            height_q   <= '0;
            width_q    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state_q)
                ST_IDLE: if (frm_start) begin
                    height_q <= frm_height;
                    width_q  <= frm_width;
                    state_q  <= (frm_full || frm_height == '0) ? ST_DRAIN : ST_SCAN;
                end
                ST_SCAN: if (step && is_last) state_q <= ST_DRAIN;
                ST_DRAIN: if (!rect_valid) begin
                    frame_done <= 1'b1;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    sc_span_track #(.ROW_W(ROW_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take_start),
        .step      (step),
        .dirty     (row_dirty),
        .height    (height_q),
        .is_last   (is_last),
        .close_fire(close_fire),
        .close_y0  (close_y0),
        .close_rows(close_rows)
    );

    sc_rect_slot #(.ROW_W(ROW_W), .COL_W(COL_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slot_load),
        .in_y0    (slot_y0),
        .in_rows  (slot_rows),
        .in_width (slot_width),
        .out_valid(rect_valid),
        .out_ready(rect_ready),
        .out_y0   (rect_y0),
        .out_rows (rect_rows),
        .out_width(rect_width)
    );

    // R8: intake is stalled while a rectangle waits
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> !row_ready);
    // R9: done never overlaps a pending rectangle
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !rect_valid);
    // R5: a rectangle never extends past the frame height
    p_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> (SUM_W'(rect_y0) + SUM_W'(rect_rows) <= SUM_W'(height_q)));
    // R7: a full update presents the whole frame on the next cycle
    p_full_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_go |=> (rect_valid && rect_y0 == '0 && rect_rows == height_q));
    // R6: the width latched at frame start is reported
    p_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> (rect_width == width_q));
endmodule

// File: tb/span_coalescer_bench.sv
module span_coalescer_bench;
    localparam int ROW_W = 11;
    localparam int COL_W = 12;
    localparam int CLK_PERIOD = 10;
    localparam int MAXR = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frm_start = 1'b0;
    logic             frm_full = 1'b0;
    logic [ROW_W-1:0] frm_height = '0;
    logic [COL_W-1:0] frm_width = '0;
    logic             row_valid = 1'b0;
    logic             row_dirty = 1'b0;
    logic             row_ready;
    logic             rect_valid;
    logic             rect_ready = 1'b0;
    logic [ROW_W-1:0] rect_y0;
    logic [ROW_W-1:0] rect_rows;
    logic [COL_W-1:0] rect_width;
    logic             frame_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic dmap [0:MAXR-1];
    int exp_y [0:MAXR-1];
    int exp_n [0:MAXR-1];
    int exp_cnt;
    int got_y [0:MAXR-1];
    int got_n [0:MAXR-1];
    int got_cnt = 0;
    int done_cnt = 0;
    int got_at_done = 0;
    int width_bad = 0;
    int stall_bad = 0;
    int hold_bad = 0;
    int ready_seen = 0;
    int exp_width = 0;
    logic prev_stall = 1'b0;
    int prev_y = 0, prev_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    span_coalescer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_span_coalescer (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_full(frm_full),
        .frm_height(frm_height), .frm_width(frm_width), .row_valid(row_valid),
        .row_dirty(row_dirty), .row_ready(row_ready), .rect_valid(rect_valid),
        .rect_ready(rect_ready), .rect_y0(rect_y0), .rect_rows(rect_rows),
        .rect_width(rect_width), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: runs at negedge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && !(rect_valid && rect_y0 == prev_y && rect_rows == prev_n))
                hold_bad++;
            if (rect_valid && row_ready) stall_bad++;
            if (row_valid && row_ready) ready_seen++;
            if (frame_done) begin
                done_cnt++;
                got_at_done = got_cnt;
                if (rect_valid) stall_bad++;
            end
            rect_ready = ($urandom % 3) == 0;
            prev_stall = rect_valid && !rect_ready;
            prev_y = int'(rect_y0);
            prev_n = int'(rect_rows);
            if (rect_valid && rect_ready) begin
                if (got_cnt < MAXR) begin
                    got_y[got_cnt] = int'(rect_y0);
                    got_n[got_cnt] = int'(rect_rows);
                end
                got_cnt++;
                if (int'(rect_width) != exp_width) width_bad++;
            end
        end
    end

    // Expected spans computed from the dirty map.
    task automatic build_expected(input int h, input bit full);
        int s;
        exp_cnt = 0;
        s = -1;
        if (h == 0) return;
        if (full) begin
            exp_y[0] = 0; exp_n[0] = h; exp_cnt = 1;
            return;
        end
        for (int r = 0; r < h; r++) begin
            if (dmap[r] && s < 0) s = r;
            if (!dmap[r] && s >= 0) begin
                exp_y[exp_cnt] = s; exp_n[exp_cnt] = r - s; exp_cnt++; s = -1;
            end
        end
        if (s >= 0) begin
            exp_y[exp_cnt] = s; exp_n[exp_cnt] = h - s; exp_cnt++;
        end
    endtask

    task automatic run_frame(input int h, input int w, input bit full, input bit inject);
        int t;
        int dirty_rows;
        build_expected(h, full);
        dirty_rows = 0;
        for (int r = 0; r < h; r++) if (dmap[r]) dirty_rows++;
        got_cnt = 0; done_cnt = 0; got_at_done = -1;
        width_bad = 0; stall_bad = 0; hold_bad = 0; ready_seen = 0;
        exp_width = w;
        @(negedge clk);
        frm_start = 1'b1; frm_full = full;
        frm_height = ROW_W'(h); frm_width = COL_W'(w);
        @(negedge clk);
        frm_start = 1'b0;
        if (full || h == 0) begin
            row_valid = 1'b1; row_dirty = 1'b1;
        end else begin
            for (int r = 0; r < h; r++) begin
                while (($urandom % 4) == 0) begin
                    row_valid = 1'b0;
                    @(negedge clk);
                end
                row_valid = 1'b1; row_dirty = dmap[r];
                if (inject && r == 1) begin
                    frm_start = 1'b1; frm_height = ROW_W'(3);
                    frm_width = COL_W'(w + 7); frm_full = 1'b1;
                end
                t = 0;
                while (!row_ready && t < 5000) begin
                    @(negedge clk);
                    t++;
                end
                @(negedge clk);
                frm_start = 1'b0;
            end
            row_valid = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        row_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        chk(got_at_done == exp_cnt, "R9 rects before done", got_at_done, exp_cnt);
        chk(got_cnt == exp_cnt, "R3 R4 R5 rect count", got_cnt, exp_cnt);
        for (int i = 0; i < exp_cnt && i < got_cnt; i++) begin
            chk(got_y[i] == exp_y[i], "R3 rect_y0", got_y[i], exp_y[i]);
            chk(got_n[i] == exp_n[i], "R4 R5 rect_rows", got_n[i], exp_n[i]);
        end
        chk(width_bad == 0, "R6 rect_width mismatches", width_bad, 0);
        chk(stall_bad == 0, "R8 intake during pending rect", stall_bad, 0);
        chk(hold_bad == 0, "R8 hold while stalled", hold_bad, 0);
        if (full || h == 0) chk(ready_seen == 0, "R7 rows consumed", ready_seen, 0);
        if (h == 0) chk(got_cnt == 0, "R11 rects for zero height", got_cnt, 0);
        if (!full && h > 0 && dirty_rows == 0)
            chk(got_cnt == 0, "R10 rects for clean frame", got_cnt, 0);
        if (inject) chk(got_cnt == exp_cnt, "R2 mid-frame start ignored", got_cnt, exp_cnt);
    endtask

    task automatic fill(input int h, input int kind);
        for (int r = 0; r < MAXR; r++) begin
            case (kind)
                0: dmap[r] = 1'b0;
                1: dmap[r] = 1'b1;
                2: dmap[r] = r[0];
                3: dmap[r] = (r == h - 1);
                4: dmap[r] = (r == 0);
                default: dmap[r] = ($urandom % 2) == 1;
            endcase
        end
    endtask

    // Watchdog: expiry counts as a failed check.
    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int h;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(rect_valid == 1'b0, "R1 rect_valid", int'(rect_valid), 0);
        chk(frame_done == 1'b0, "R1 frame_done", int'(frame_done), 0);
        chk(row_ready == 1'b0, "R1 row_ready", int'(row_ready), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Directed corner cases
        fill(20, 1); run_frame(20, 640, 1'b0, 1'b0);   // one long span to the end (R5)
        fill(20, 0); run_frame(20, 640, 1'b0, 1'b0);   // clean frame (R10)
        fill(17, 2); run_frame(17, 320, 1'b0, 1'b0);   // alternating rows (R3, R4)
        fill(9, 3);  run_frame(9, 100, 1'b0, 1'b0);    // span opens on last row (R5)
        fill(9, 4);  run_frame(9, 100, 1'b0, 1'b0);    // single first row (R4)
        fill(1, 1);  run_frame(1, 64, 1'b0, 1'b0);     // height 1, dirty
        fill(1, 0);  run_frame(1, 64, 1'b0, 1'b0);     // height 1, clean
        fill(30, 0); run_frame(30, 800, 1'b1, 1'b0);   // full update (R7)
        fill(0, 1);  run_frame(0, 800, 1'b0, 1'b0);    // height 0 (R11)
        fill(0, 1);  run_frame(0, 800, 1'b1, 1'b0);    // height 0, full (R11)
        fill(12, 5); run_frame(12, 200, 1'b0, 1'b1);   // mid-frame start (R2)
        // Constrained random frames
        for (int f = 0; f < 40; f++) begin
            h = 1 + int'($urandom % 64);
            fill(h, 5);
            run_frame(h, 64 + int'($urandom % 1900), ($urandom % 8) == 0, 1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule